// File: doc/BRIEF.md
# Two-Way Instruction Cache

This block sits between a processor's instruction fetch port and a slow external memory port. The processor issues 32-bit word fetches with 24-bit byte addresses. The cache keeps recently fetched code in two ways of tagged four-word lines and answers repeated fetches without touching memory. On a miss it fetches the whole line as one four-word burst, writes the words in as they arrive, and hands the wanted word to the processor as soon as that word lands. It does not wait for the line to finish.

Three controls shape its behaviour. An enable input turns lookup off, and each fetch then becomes a single-word memory read. A flush pulse starts a sweep that invalidates every line, and a busy flag shows the sweep in progress. A freeze input locks the stored contents: hits are still served, while misses are fetched and forwarded but leave no trace. Hit latency depends on the request stream. A fetch that follows the previous hit in the very next cycle and targets the next word address costs one cycle. Any other hit costs two.

Top module: `icache2w`

## Requirements
- R1: The word address splits as follows: byte address bits [3:2] select the word in the line, bits [IDX_W+3:4] select the set (9 bits by default), and the bits above are the tag. Bits [1:0] have no effect on lookup or on the returned data.
- R2: A fetch hits only when one way of its set holds a valid line whose tag equals the fetch tag. A fetch to a set whose valid lines carry other tags is a miss.
- R3: On an enabled miss the block raises `mem_req` for one cycle with `mem_burst`=1 and `mem_addr` equal to the line base (low four bits zero). It then accepts four words on `mem_rvalid`, in ascending word order.
- R4: During a fill, `cpu_rdy` rises with the requested word in the cycle after that word is presented on `mem_rvalid`, even if later words of the line are still outstanding.
- R5: A line becomes valid, with its tag, only after its fourth word is written. From then on any word of that line hits without a memory request.
- R6: Each set has one replacement bit naming its least recently used way. A hit or a fill marks the way used, and a miss refills the way that the bit names.
- R7: With `cpu_en` low, every fetch raises `mem_req` with `mem_burst`=0 and the word-aligned byte address, returns that word, and changes no cache state.
- R8: A one-cycle `flush_start` pulse raises `flush_busy` in the next cycle. `flush_busy` stays high for exactly 2^IDX_W cycles and then clears by itself, and every line is invalid afterwards. New fetches wait while it is high.
- R9: With `cpu_freeze` high, hits are served normally. A miss still requests a four-word burst and returns the word, but it changes no tag, data, valid or replacement state.
- R10: A hit returns in 2 cycles after the request is first sampled. A hit requested in the cycle right after a hit's `cpu_rdy` cycle, to the next word address, returns in 1 cycle.
- R11: After reset `cpu_rdy`, `mem_req` and `flush_busy` are low, every line is invalid, and no flush or fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | 1: cache lookup; 0: single-word pass-through |
| cpu_freeze | input | 1 | 1: cache contents and replacement state locked |
| flush_start | input | 1 | Pulse to start invalidating all lines |
| flush_busy | output | 1 | High while the invalidation sweep runs |
| cpu_req | input | 1 | Fetch request, held with its address until `cpu_rdy` |
| cpu_addr | input | ADDR_W | Byte fetch address |
| cpu_rdy | output | 1 | One-cycle strobe: `cpu_rdata` is valid |
| cpu_rdata | output | DATA_W | Fetched instruction word |
| mem_req | output | 1 | One-cycle memory read request |
| mem_burst | output | 1 | 1: four-word line read; 0: single word |
| mem_addr | output | ADDR_W | Byte address of the memory read |
| mem_rvalid | input | 1 | A memory word is present this cycle |
| mem_rdata | input | DATA_W | Memory word |

## Verification
The bench builds the cache with IDX_W=3, so it has 8 sets and the tag grows to 17 bits. Conflicting lines in one set, eviction by the replacement bit, and a complete flush sweep then all fit in a handful of fetches. A flush of 8 cycles can be timed exactly. The memory model answers after a fixed delay of 3 cycles. This lets the bench predict the cycle in which a forwarded word must appear for each word position in the line.

// File: rtl/icache2w_pkg.sv
package icache2w_pkg;

    // Words per line is fixed at four 32-bit words: two offset bits.
    localparam int OFS_W      = 2;
    localparam int LINE_WORDS = 1 << OFS_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RESP,
        ST_FILL,
        ST_BYP
    } ic_state_e;

    // Context of a line fill in progress.
    typedef struct packed {
        logic             way;
        logic             frozen;
        logic [OFS_W-1:0] cnt;
    } fill_ctx_t;

    function automatic logic is_last_word(input logic [OFS_W-1:0] cnt);
        return cnt == OFS_W'(LINE_WORDS - 1);
    endfunction

endpackage

// File: rtl/icache2w_tags.sv
module icache2w_tags
    import icache2w_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim,
    input  logic             lru_we,
    input  logic [IDX_W-1:0] lru_idx,
    input  logic             lru_used,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             flush_start,
    output logic             flush_busy
);
    localparam int SETS = 1 << IDX_W;

    logic [1:0]       match;
    logic [SETS-1:0]  lru_q;
    logic [IDX_W-1:0] sweep_q;
    logic             busy_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        always_ff @(posedge clk) begin
            if (fill_we && fill_way == 1'(w))
                tag_q[fill_idx] <= fill_tag;
        end

        // Sweep wins over a fill completing during the flush.
        always_ff @(posedge clk) begin
            if (rst)
                vld_q <= '0;
            else if (busy_q)
                vld_q[sweep_q] <= 1'b0;
            else if (fill_we && fill_way == 1'(w))
                vld_q[fill_idx] <= 1'b1;
        end

        assign match[w] = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
    end

    assign hit     = |match;
    assign hit_way = match[1];
    assign victim  = lru_q[look_idx];

    // Bit value names the way to replace next.
    always_ff @(posedge clk) begin
        if (rst)
            lru_q <= '0;
        else if (lru_we)
            lru_q[lru_idx] <= ~lru_used;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sweep_q <= '0;
        end else if (busy_q) begin
            sweep_q <= sweep_q + IDX_W'(1);
            if (&sweep_q)
                busy_q <= 1'b0;
        end else if (flush_start) begin
            busy_q  <= 1'b1;
            sweep_q <= '0;
        end
    end

    assign flush_busy = busy_q;

endmodule

// File: rtl/icache2w_data.sv
module icache2w_data
    import icache2w_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = (1 << IDX_W) * LINE_WORDS;

    logic [DATA_W-1:0] rd_w [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wr_way == 1'(w))
                mem_q[{wr_idx, wr_ofs}] <= wr_data;
        end

        assign rd_w[w] = mem_q[{rd_idx, rd_ofs}];
    end

    assign rd_data = rd_way ? rd_w[1] : rd_w[0];

endmodule

// File: rtl/icache2w.sv
module icache2w
    import icache2w_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_en,
    input  logic              cpu_freeze,
    input  logic              flush_start,
    output logic              flush_busy,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WA_W  = ADDR_W - 2;          // word address width
    localparam int TAG_W = WA_W - IDX_W - OFS_W;

    ic_state_e         state_q;
    logic [WA_W-1:0]   cap_q;
    fill_ctx_t         fill_q;
    logic              rdy_q, mreq_q, mburst_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ADDR_W-1:0] maddr_q;

    logic [WA_W-1:0]   cpu_wa, look_wa;
    logic              seq_ok, do_look, accept;
    logic              hit, hit_way, victim;
    logic              lru_we, lru_used, fill_last;
    logic [IDX_W-1:0]  lru_idx;
    logic [DATA_W-1:0] rd_data;
    logic              unused_byte;

    assign cpu_wa      = cpu_addr[ADDR_W-1:2];
    assign unused_byte = ^cpu_addr[1:0];

    // Back-to-back fetch of the next word straight after a hit.
    assign seq_ok  = (state_q == ST_RESP) && cpu_req && cpu_en && !flush_busy
                     && (cpu_wa == cap_q + WA_W'(1));
    assign look_wa = seq_ok ? cpu_wa : cap_q;
    assign do_look = (state_q == ST_LOOK) || seq_ok;
    assign accept  = ((state_q == ST_IDLE) || (state_q == ST_RESP))
                     && cpu_req && !flush_busy;

    assign fill_last = (state_q == ST_FILL) && mem_rvalid
                       && is_last_word(fill_q.cnt) && !fill_q.frozen;

    always_comb begin
        lru_we   = 1'b0;
        lru_idx  = look_wa[IDX_W+OFS_W-1:OFS_W];
        lru_used = hit_way;
        if (do_look && hit && !cpu_freeze) begin
            lru_we = 1'b1;
        end else if (fill_last) begin
            lru_we   = 1'b1;
            lru_idx  = cap_q[IDX_W+OFS_W-1:OFS_W];
            lru_used = fill_q.way;
        end
    end

    icache2w_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk         (clk),
        .rst         (rst),
        .look_idx    (look_wa[IDX_W+OFS_W-1:OFS_W]),
        .look_tag    (look_wa[WA_W-1:IDX_W+OFS_W]),
        .hit         (hit),
        .hit_way     (hit_way),
        .victim      (victim),
        .lru_we      (lru_we),
        .lru_idx     (lru_idx),
        .lru_used    (lru_used),
        .fill_we     (fill_last),
        .fill_idx    (cap_q[IDX_W+OFS_W-1:OFS_W]),
        .fill_way    (fill_q.way),
        .fill_tag    (cap_q[WA_W-1:IDX_W+OFS_W]),
        .flush_start (flush_start),
        .flush_busy  (flush_busy)
    );

    icache2w_data #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .rd_way  (hit_way),
        .rd_idx  (look_wa[IDX_W+OFS_W-1:OFS_W]),
        .rd_ofs  (look_wa[OFS_W-1:0]),
        .rd_data (rd_data),
        .we      ((state_q == ST_FILL) && mem_rvalid && !fill_q.frozen),
        .wr_way  (fill_q.way),
        .wr_idx  (cap_q[IDX_W+OFS_W-1:OFS_W]),
        .wr_ofs  (fill_q.cnt),
        .wr_data (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cap_q    <= '0;
            fill_q   <= '0;
            rdy_q    <= 1'b0;
            rdata_q  <= '0;
            mreq_q   <= 1'b0;
            mburst_q <= 1'b0;
            maddr_q  <= '0;
        end else begin
            rdy_q  <= 1'b0;
            mreq_q <= 1'b0;
            if (do_look) begin
                cap_q <= look_wa;
                if (hit) begin
                    rdy_q   <= 1'b1;
                    rdata_q <= rd_data;
                    state_q <= ST_RESP;
                end else begin
                    state_q       <= ST_FILL;
                    mreq_q        <= 1'b1;
                    mburst_q      <= 1'b1;
                    maddr_q       <= {look_wa[WA_W-1:OFS_W], {(OFS_W+2){1'b0}}};
                    fill_q.way    <= victim;
                    fill_q.frozen <= cpu_freeze;
                    fill_q.cnt    <= '0;
                end
            end else if (accept) begin
                cap_q <= cpu_wa;
                if (cpu_en) begin
                    state_q <= ST_LOOK;
                end else begin
                    state_q  <= ST_BYP;
                    mreq_q   <= 1'b1;
                    mburst_q <= 1'b0;
                    maddr_q  <= {cpu_wa, 2'b00};
                end
            end else if (state_q == ST_FILL) begin
                if (mem_rvalid) begin
                    fill_q.cnt <= fill_q.cnt + OFS_W'(1);
                    if (fill_q.cnt == cap_q[OFS_W-1:0]) begin
                        rdy_q   <= 1'b1;
                        rdata_q <= mem_rdata;
                    end
                    if (is_last_word(fill_q.cnt))
                        state_q <= ST_IDLE;
                end
            end else if (state_q == ST_BYP) begin
                if (mem_rvalid) begin
                    rdy_q   <= 1'b1;
                    rdata_q <= mem_rdata;
                    state_q <= ST_IDLE;
                end
            end else if (state_q == ST_RESP) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign cpu_rdy   = rdy_q;
    assign cpu_rdata = rdata_q;
    assign mem_req   = mreq_q;
    assign mem_burst = mburst_q;
    assign mem_addr  = maddr_q;

endmodule

// File: rtl/icache2w_chk.sv
module icache2w_chk #(
    parameter int IDX_W = 9
) (
    input logic       clk,
    input logic       rst,
    input logic       cpu_req,
    input logic       cpu_rdy,
    input logic       mem_req,
    input logic       mem_burst,
    input logic [3:0] mem_addr_lo,
    input logic       flush_start,
    input logic       flush_busy
);
    localparam int SETS = 1 << IDX_W;

    int busy_cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt_q <= 0;
        else if (flush_busy)
            busy_cnt_q <= busy_cnt_q + 1;
        else
            busy_cnt_q <= 0;
    end

    // R3: a line request carries the line base address
    a_r3_burst_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_burst) |-> (mem_addr_lo == 4'h0));

    // R3: a memory request lasts one cycle
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R10: data strobes answer a held request
    a_r10_rdy_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |-> $past(cpu_req));

    // R8: a pulse starts the sweep
    a_r8_flush_starts: assert property (@(posedge clk) disable iff (rst)
        (flush_start && !flush_busy) |=> flush_busy);

    // R8: the sweep ends by itself
    a_r8_flush_bounded: assert property (@(posedge clk) disable iff (rst)
        busy_cnt_q <= SETS);

    // R11: quiet outputs straight after reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_rdy && !mem_req && !flush_busy));

endmodule

bind icache2w icache2w_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .cpu_rdy     (cpu_rdy),
    .mem_req     (mem_req),
    .mem_burst   (mem_burst),
    .mem_addr_lo (mem_addr[3:0]),
    .flush_start (flush_start),
    .flush_busy  (flush_busy)
);

// File: tb/icache2w_tb_top.sv
`timescale 1ns/1ps
module icache2w_tb_top;
    localparam int IDX_W   = 3;
    localparam int SETS    = 1 << IDX_W;
    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_en = 1'b0, cpu_freeze = 1'b0, flush_start = 1'b0;
    logic        flush_busy;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_rdy;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_burst;
    logic [23:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    icache2w #(.ADDR_W(24), .DATA_W(32), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_freeze(cpu_freeze),
        .flush_start(flush_start), .flush_busy(flush_busy),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rdy(cpu_rdy),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mw(input logic [23:0] a);
        return {a[23:2], 10'h000} ^ {10'h000, a[23:2]} ^ 32'hC3A5_1E69;
    endfunction

    function automatic logic [23:0] mk(input int tag, input int set, input int ofs);
        return {17'(tag), 3'(set), 2'(ofs), 2'b00};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // External memory model
    int          m_left = 0, m_delay = 0, m_word = 0, m_tgt = 0;
    int          n_burst = 0, n_single = 0, tgt_cyc = -1, exp_ofs = 0;
    logic [23:0] m_base = '0, last_maddr = '0;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (m_left > 0) begin
            if (m_delay > 0) m_delay--;
            else begin
                mem_rvalid = 1'b1;
                mem_rdata  = mw(m_base + 24'(m_word * 4));
                if (m_word == m_tgt) tgt_cyc = cyc;
                m_word++;
                m_left--;
            end
        end
        if (mem_req) begin
            last_maddr = mem_addr;
            m_base  = mem_addr;
            m_left  = mem_burst ? 4 : 1;
            m_delay = MEM_LAT;
            m_word  = 0;
            m_tgt   = mem_burst ? exp_ofs : 0;
            if (mem_burst) n_burst++; else n_single++;
        end
    end

    // Reference cache state
    bit mv [2][SETS];
    int mt [2][SETS];
    bit ml [SETS];
    logic [23:0] prev_a = '0;

    function automatic int mlook(input logic [23:0] a);
        for (int w = 0; w < 2; w++)
            if (mv[w][int'(a[IDX_W+3:4])] && mt[w][int'(a[IDX_W+3:4])] == int'(a[23:IDX_W+4]))
                return w;
        return -1;
    endfunction

    task automatic fetch(input logic [23:0] a, input bit chained, input string rq);
        int w, s, start, nb0, ns0, lat, to;
        s = int'(a[IDX_W+3:4]);
        w = cpu_en ? mlook(a) : -1;
        nb0 = n_burst; ns0 = n_single;
        exp_ofs = int'(a[3:2]);
        cpu_req = 1'b1; cpu_addr = a; start = cyc; to = 0;
        do begin @(negedge clk); to++; end while (!cpu_rdy && to < 100);
        lat = cyc - start;
        chk(cpu_rdy == 1'b1, rq, "rdy seen", 32'(cpu_rdy), 1);
        chk(cpu_rdata == mw(a), rq, "fetched word", cpu_rdata, mw(a));
        if (!cpu_en) begin
            chk(n_single == ns0 + 1 && n_burst == nb0, "R7", "single-word access",
                32'(n_single - ns0), 1);
            chk(last_maddr == {a[23:2], 2'b00}, "R7", "pass-through address",
                32'(last_maddr), 32'({a[23:2], 2'b00}));
        end else if (w >= 0) begin
            int el = (chained && a[23:2] == prev_a[23:2] + 22'd1) ? 1 : 2;
            chk(lat == el, "R10", "hit latency", 32'(lat), 32'(el));
            chk(n_burst == nb0, "R5", "hit needs no memory", 32'(n_burst - nb0), 0);
            if (!cpu_freeze) ml[s] = ~1'(w);
        end else begin
            chk(n_burst == nb0 + 1, "R3", "one burst per miss", 32'(n_burst - nb0), 1);
            chk(last_maddr == {a[23:4], 4'h0}, "R3", "burst at line base",
                32'(last_maddr), 32'({a[23:4], 4'h0}));
            chk(cyc == tgt_cyc + 1, "R4", "forward cycle", 32'(cyc), 32'(tgt_cyc + 1));
            if (!cpu_freeze) begin
                int v = int'(ml[s]);
                mv[v][s] = 1'b1; mt[v][s] = int'(a[23:IDX_W+4]); ml[s] = ~ml[s];
            end
        end
        prev_a = a;
    endtask

    task automatic rest();
        cpu_req = 1'b0;
        @(negedge clk);
        while (m_left > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cpu_rdy == 1'b0, "R4", "no stray rdy", 32'(cpu_rdy), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bc;
        for (int s = 0; s < SETS; s++) begin mv[0][s] = 0; mv[1][s] = 0; ml[s] = 0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_rdy == 0 && mem_req == 0 && flush_busy == 0, "R11", "reset outputs",
            {29'd0, cpu_rdy, mem_req, flush_busy}, 0);
        cpu_en = 1'b1;

        // R11/R3/R4: first access misses; middle word forwarded mid-fill
        fetch(mk(5, 2, 1), 0, "R11"); rest();
        // R1/R5: other word of line with byte bits set hits
        fetch(mk(5, 2, 3) | 24'h3, 0, "R1"); rest();
        // R10: sequential chain, then next line miss (R3) with word 0
        fetch(mk(5, 2, 0), 0, "R10");
        fetch(mk(5, 2, 1), 1, "R10");
        fetch(mk(5, 2, 2), 1, "R10");
        fetch(mk(5, 2, 3), 1, "R10");
        fetch(mk(5, 3, 0), 1, "R3"); rest();
        // R10: back-to-back but non-sequential costs two cycles
        fetch(mk(5, 2, 0), 0, "R10");
        fetch(mk(5, 2, 2), 1, "R10"); rest();
        // R2: same set, other tag misses; last word forwarded (R4)
        fetch(mk(9, 2, 3), 0, "R2"); rest();
        // R6: touch tag 5, then a third tag evicts tag 9
        fetch(mk(5, 2, 1), 0, "R6"); rest();
        fetch(mk(11, 2, 2), 0, "R6"); rest();
        fetch(mk(5, 2, 0), 0, "R6"); rest();
        chk(mlook(mk(9, 2, 0)) == -1, "R6", "model evicted way", 0, 0);
        fetch(mk(9, 2, 0), 0, "R6"); rest();

        // R9: frozen miss fetched but not kept; hits still served
        cpu_freeze = 1'b1;
        fetch(mk(20, 4, 2), 0, "R9"); rest();
        fetch(mk(20, 4, 2), 0, "R9"); rest();
        fetch(mk(5, 3, 1), 0, "R9"); rest();
        cpu_freeze = 1'b0;

        // R7: pass-through leaves no line behind
        cpu_en = 1'b0;
        fetch(mk(30, 5, 3) | 24'h2, 0, "R7"); rest();
        cpu_en = 1'b1;
        fetch(mk(30, 5, 3), 0, "R7"); rest();

        // R8: flush sweep length and effect
        flush_start = 1'b1;
        @(negedge clk);
        flush_start = 1'b0;
        chk(flush_busy == 1'b1, "R8", "busy after pulse", 32'(flush_busy), 1);
        bc = 0;
        while (flush_busy && bc < 100) begin bc++; @(negedge clk); end
        chk(bc == SETS, "R8", "busy cycles", 32'(bc), 32'(SETS));
        for (int s = 0; s < SETS; s++) begin mv[0][s] = 0; mv[1][s] = 0; end
        fetch(mk(5, 3, 1), 0, "R8"); rest();
        fetch(mk(30, 5, 0), 0, "R8"); rest();

        finish_run();
    end

endmodule